// File: doc/BRIEF.md
# Channel Power-Up Sequencer

This block brings a set of output channels (four by default) up and down in a safe order. Each channel has one request bit. Clearing the bit asks for the channel to be powered. Setting it asks for the channel to be shut off. A small state machine per channel drives three enable controls for the analog section it governs: internal bias enable, boost-converter enable and output-stage enable.

Power-up happens in two stages. In the first stage the internal and boost-converter enables turn on together. The output stage turns on only after a fixed settling gap, which is 200 microseconds by default. The gap is converted to clock cycles from the `CLK_HZ` parameter at elaboration time. Power-down is immediate: all three enables drop on one clock edge, including when the settling gap is still running. Each channel keeps its own counter and its own state, so channels never wait for one another.

All interfaces are plain level signals. There is no data stream and no handshake. The request bits are sampled on every rising clock edge.

Top module: `chan_pwr_sequencer`

## Requirements
- R1: After reset every channel is powered down: `int_en`, `dcdc_en`, `out_en` and `busy` are all 0.
- R2: Request encoding: `pd_req[i]`=1 requests power-down and 0 requests power-up. When a powered-down channel samples `pd_req[i]`=0, the next edge sets `int_en[i]` and `dcdc_en[i]` to 1, leaves `out_en[i]` at 0 and raises `busy[i]`.
- R3: `out_en[i]` rises exactly WAIT_CYC = CLK_HZ*SETTLE_US/1e6 clock edges after `int_en[i]` rises, which is 200 at the defaults. `busy[i]` falls on that same edge. `out_en[i]` is never 1 while `int_en[i]` or `dcdc_en[i]` is 0.
- R4: When a fully powered channel samples `pd_req[i]`=1, the next edge clears all three enables together and `busy[i]` stays 0.
- R5: When a channel samples `pd_req[i]`=1 during the settling gap, the next edge aborts the sequence: all enables go to 0 and `busy[i]` goes to 0. A later power-up request waits the full WAIT_CYC again.
- R6: A request equal to the current state does nothing. Holding 0 on a powered or settling channel neither restarts nor lengthens the gap. Holding 1 on a powered-down channel keeps it off.
- R7: Channels are independent. The request of one channel never changes the enables, the busy flag or the settling timing of another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, frequency CLK_HZ |
| rst_n | input | 1 | Active-low reset |
| pd_req | input | NUM_CH | Per-channel request, 1 = power down, 0 = power up |
| int_en | output | NUM_CH | Internal bias enable per channel |
| dcdc_en | output | NUM_CH | Boost converter enable per channel |
| out_en | output | NUM_CH | Output stage enable per channel |
| busy | output | NUM_CH | High while a channel waits out its settling gap |

## Verification
The assertions check the ordering rules on every cycle. The output stage is never on without both supply enables. The first stage always raises the two supply enables together. A power-down request always clears everything on the next edge. A checker counter confirms that every output-enable rise comes exactly WAIT_CYC edges after the sequence began. The bench scenarios are the only place that shows the properties of whole sequences: that an aborted gap starts again from zero, that held requests cause no restart, and that staggered requests on neighbouring channels leave each other's timing untouched.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [1:0] {
    CH_OFF    = 2'd0,
    CH_SETTLE = 2'd1,
    CH_ON     = 2'd2
  } ch_state_e;

  function automatic int settle_cycles(input longint clk_hz, input longint gap_us);
    return int'((clk_hz * gap_us) / 64'd1000000);
  endfunction

endpackage

// File: rtl/pwrseq_delay.sv
module pwrseq_delay #(
  parameter int WAIT_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic expired
);
  localparam int CW = (WAIT_CYC > 2) ? $clog2(WAIT_CYC) : 1;
  localparam logic [CW-1:0] LOAD = CW'(WAIT_CYC - 1);

  logic [CW-1:0] cnt;
  logic          running;

  assign expired = running && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (abort) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (start) begin
      cnt     <= LOAD;
      running <= 1'b1;
    end else if (running) begin
      if (cnt == '0) running <= 1'b0;
      else           cnt     <= cnt - 1'b1;
    end
  end

  // R3: the count never leaves its loaded range
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt <= LOAD));

  // R5: abort stops the count on the next edge
  a_r5_abort_stops: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !running);

endmodule

// File: rtl/pwrseq_chan.sv
module pwrseq_chan
  import pwrseq_pkg::*;
#(
  parameter int WAIT_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_req,
  output logic int_en,
  output logic dcdc_en,
  output logic out_en,
  output logic busy
);
  ch_state_e state, state_nx;
  logic      tmr_start, tmr_abort, tmr_expired;

  assign tmr_start = (state == CH_OFF) && !pd_req;
  assign tmr_abort = pd_req;

  pwrseq_delay #(.WAIT_CYC(WAIT_CYC)) i_delay (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (tmr_start),
    .abort   (tmr_abort),
    .expired (tmr_expired)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      CH_OFF:    if (!pd_req) state_nx = CH_SETTLE;
      CH_SETTLE: if (pd_req) state_nx = CH_OFF;
                 else if (tmr_expired) state_nx = CH_ON;
      CH_ON:     if (pd_req) state_nx = CH_OFF;
      default:   state_nx = CH_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= CH_OFF;
    else        state <= state_nx;
  end

  assign int_en  = (state != CH_OFF);
  assign dcdc_en = (state != CH_OFF);
  assign out_en  = (state == CH_ON);
  assign busy    = (state == CH_SETTLE);

  // Checker counter: edges spent in the settling stage
  int chk_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    chk_cnt <= 0;
    else if (busy) chk_cnt <= chk_cnt + 1;
    else           chk_cnt <= 0;
  end

  // R3: the output stage only with both supply enables
  a_r3_out_needs_supply: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |-> (int_en && dcdc_en));

  // R3: output enable rises exactly after the full gap
  a_r3_gap_exact: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_en) |-> (chk_cnt == WAIT_CYC));

  // R2: the first stage raises both supplies together, output still off
  a_r2_first_stage: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_en) |-> ($rose(dcdc_en) && !out_en && busy));

  // R4/R5: a power-down request clears everything on the next edge
  a_r4_drop_all: assert property (@(posedge clk) disable iff (!rst_n)
    pd_req |=> (!int_en && !dcdc_en && !out_en && !busy));

  // R6: a held power-up request on a running channel keeps it running
  a_r6_hold_on: assert property (@(posedge clk) disable iff (!rst_n)
    (!pd_req && out_en) |=> (out_en && !busy));

endmodule

// File: rtl/chan_pwr_sequencer.sv
module chan_pwr_sequencer
  import pwrseq_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int CLK_HZ    = 1_000_000,
  parameter int SETTLE_US = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] pd_req,
  output logic [NUM_CH-1:0] int_en,
  output logic [NUM_CH-1:0] dcdc_en,
  output logic [NUM_CH-1:0] out_en,
  output logic [NUM_CH-1:0] busy
);
  localparam int WAIT_RAW = settle_cycles(longint'(CLK_HZ), longint'(SETTLE_US));
  localparam int WAIT_CYC = (WAIT_RAW < 2) ? 2 : WAIT_RAW;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pwrseq_chan #(.WAIT_CYC(WAIT_CYC)) i_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .pd_req  (pd_req[g]),
      .int_en  (int_en[g]),
      .dcdc_en (dcdc_en[g]),
      .out_en  (out_en[g]),
      .busy    (busy[g])
    );
  end

  // R1: right after reset nothing is enabled
  a_r1_reset_off: assert property (@(posedge clk)
    $rose(rst_n) |-> (int_en == '0 && out_en == '0 && busy == '0));

endmodule

// File: tb/test_chan_pwr_sequencer.sv
module test_chan_pwr_sequencer;
  localparam int  NCH = 4;
  localparam time PER = 10;
  localparam int  W   = 200;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] pd_req = '1;
  logic [NCH-1:0] int_en, dcdc_en, out_en, busy;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(PER/2) clk = ~clk;

  chan_pwr_sequencer i_chan_pwr_sequencer (
    .clk(clk), .rst_n(rst_n), .pd_req(pd_req),
    .int_en(int_en), .dcdc_en(dcdc_en), .out_en(out_en), .busy(busy)
  );

  typedef struct {
    logic [NCH-1:0] ie, de, oe, bz;
    string          tag;
  } exp_t;

  exp_t q[$];
  int   m_st [NCH];
  int   m_cnt[NCH];
  string cur_tag = "R1";

  task automatic compare(input exp_t e);
    checks++;
    if (int_en !== e.ie || dcdc_en !== e.de || out_en !== e.oe || busy !== e.bz) begin
      errors++;
      $display("FAIL %s: got int=%b dcdc=%b out=%b busy=%b, expected int=%b dcdc=%b out=%b busy=%b",
               e.tag, int_en, dcdc_en, out_en, busy, e.ie, e.de, e.oe, e.bz);
    end
  endtask

  // driver: apply a request vector for one edge and predict the result
  task automatic step(input logic [NCH-1:0] req);
    exp_t e;
    @(negedge clk);
    pd_req = req;
    for (int c = 0; c < NCH; c++) begin
      case (m_st[c])
        0: if (!req[c]) begin m_st[c] = 1; m_cnt[c] = 0; end
        1: if (req[c]) m_st[c] = 0;
           else begin m_cnt[c]++; if (m_cnt[c] == W) m_st[c] = 2; end
        default: if (req[c]) m_st[c] = 0;
      endcase
      e.ie[c] = (m_st[c] != 0);
      e.de[c] = (m_st[c] != 0);
      e.oe[c] = (m_st[c] == 2);
      e.bz[c] = (m_st[c] == 1);
    end
    e.tag = cur_tag;
    q.push_back(e);
  endtask

  task automatic hold(input logic [NCH-1:0] req, input int n);
    for (int k = 0; k < n; k++) step(req);
  endtask

  // monitor: compare after each edge
  initial begin
    forever begin
      @(posedge clk);
      #(PER/4);
      if (q.size() > 0) compare(q.pop_front());
    end
  end

  initial begin
    #(PER*100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    exp_t z;
    for (int c = 0; c < NCH; c++) begin m_st[c] = 0; m_cnt[c] = 0; end
    z.ie = '0; z.de = '0; z.oe = '0; z.bz = '0; z.tag = "R1";
    #(PER*3 + PER/4);
    compare(z);                        // R1 during reset
    @(negedge clk); rst_n = 1'b1;
    cur_tag = "R1"; hold('1, 2);
    cur_tag = "R6"; hold('1, 3);       // R6 off stays off
    cur_tag = "R3"; hold(4'b1110, W + 5);  // R2/R3/R7 channel 0 up, others off
    cur_tag = "R6"; hold(4'b1110, 10); // R6 held on, no restart
    cur_tag = "R5"; hold(4'b1100, 60); // channel 1 starts
    hold(4'b1110, 2);                  // R5 abort during gap
    cur_tag = "R5"; hold(4'b1100, W + 3);  // R5 full gap again
    cur_tag = "R7"; hold(4'b0000, 50); // R7 channels 2,3 start staggered
    cur_tag = "R4"; hold(4'b0001, 3);  // R4 channel 0 down, R7 others keep timing
    cur_tag = "R7"; hold(4'b0000, W);  // R7 channel 0 restarts, 2,3 finish
    cur_tag = "R4"; hold(4'b1111, 4);  // R4 all down at once
    hold('1, 2);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule